// File: doc/BRIEF.md
# Battery Overvoltage Fault Monitor

This block takes the digital output of a battery-overvoltage comparator, which trips when the battery sits about 5% above its regulation level. It protects the cell without waiting for a clock edge. As soon as the flag is seen, it tells the switching converter to stop and turns on the battery discharge FET. The event is latched, so a cell that drops back under the overvoltage level but is still above the recharge level stays in protection. The event clears only when the battery falls below the recharge threshold, or when the charger enters high-impedance mode. High-impedance mode is entered either through the high-impedance control bit or through the disable pin.

The block reports a status fault separately from the protective action. The fault bit is set only after the comparator flag has stayed high for a deglitch interval, nominally 1 ms. The interval's length in clock cycles comes from the clock frequency parameter. If the flag drops before the interval ends, the count starts again. Once set, the fault bit follows the same clearing rules as the protective event.

Top module: `bovp_monitor`

## Requirements
- R1: During and after reset, with all inputs low, `conv_off_o`, `fet_on_o` and `fault_o` are 0.
- R2: With no clear condition present, `ovp_i` = 1 drives `conv_off_o` and `fet_on_o` to 1 in the same cycle, before any clock edge.
- R3: After `ovp_i` returns to 0, `conv_off_o` and `fet_on_o` stay at 1 for as long as `below_rch_i`, `hiz_i` and `dis_i` are all 0.
- R4: `below_rch_i` = 1 drops `conv_off_o` and `fet_on_o` to 0 in the same cycle. After the next rising edge the event stays cleared, provided `ovp_i` is 0.
- R5: `hiz_i` = 1 releases both action outputs in the same cycle. It clears `fault_o` at the next rising edge.
- R6: `dis_i` = 1 has the same effect as `hiz_i`: both action outputs are released at once and `fault_o` is cleared at the next rising edge.
- R7: `fault_o` rises only after `ovp_i` has been sampled high, with no clear condition, on DG consecutive rising edges. DG = (CLK_FREQ_HZ / 1e6) x DEGLITCH_US. After DG-1 such edges `fault_o` is still 0.
- R8: If `ovp_i` is sampled low on any edge before DG is reached, the count restarts. Two runs of DG-1 edges separated by one low edge do not set `fault_o`.
- R9: Once set, `fault_o` stays at 1 after `ovp_i` falls, until `below_rch_i`, `hiz_i` or `dis_i` is sampled at 1.
- R10: A clear condition takes priority over `ovp_i`. While any clear input is 1, the action outputs are 0 and the deglitch count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovp_i | input | 1 | Battery overvoltage comparator flag |
| below_rch_i | input | 1 | Battery below recharge threshold |
| hiz_i | input | 1 | High-impedance mode control bit |
| dis_i | input | 1 | Charge disable pin level |
| conv_off_o | output | 1 | Force switching converter off |
| fet_on_o | output | 1 | Turn battery discharge FET on |
| fault_o | output | 1 | Deglitched overvoltage status fault |

## Verification
The monitor is driven with flag pulses of three shapes. A single-cycle glitch shows that the protective action is latched while the status fault stays quiet. A sustained flag of exactly DG edges locates the deglitch boundary to within one cycle, with one check just before the boundary and one on it. A run of DG-1 edges, a one-cycle dropout and a second run of DG-1 edges tells a restarting counter apart from a cumulative one. Each of the three clear inputs is applied on its own after a latched fault, and once together with a live flag. This shows that every clear input releases the outputs, and that clearing has priority over the flag.

// File: rtl/bovp_pkg.sv
package bovp_pkg;
  function automatic int unsigned dg_cycles(input int unsigned clk_hz, input int unsigned win_us);
    int unsigned c;
    c = (clk_hz / 1_000_000) * win_us;
    return (c < 2) ? 2 : c;
  endfunction
endpackage

// File: rtl/bovp_event.sv
module bovp_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic act_o
);
  logic evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     evt_q <= 1'b0;
    else if (clr_i)  evt_q <= 1'b0;
    else if (set_i)  evt_q <= 1'b1;
  end

  // action is combinational on the flag so protection needs no edge
  assign act_o = (set_i | evt_q) & ~clr_i;
endmodule

// File: rtl/bovp_deglitch.sv
module bovp_deglitch #(
  parameter int unsigned DG = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clr_i,
  output logic flt_o
);
  localparam int unsigned CNT_W = $clog2(DG + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DG - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (arm_i && !flt_q) begin
      if (cnt_q == LAST) begin
        flt_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/bovp_monitor.sv
module bovp_monitor #(
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int unsigned DEGLITCH_US = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovp_i,
  input  logic below_rch_i,
  input  logic hiz_i,
  input  logic dis_i,
  output logic conv_off_o,
  output logic fet_on_o,
  output logic fault_o
);
  import bovp_pkg::*;

  localparam int unsigned DG_CYC = dg_cycles(CLK_FREQ_HZ, DEGLITCH_US);

  logic clr;
  logic act;

  assign clr = below_rch_i | hiz_i | dis_i;

  bovp_event i_event (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovp_i),
    .clr_i  (clr),
    .act_o  (act)
  );

  bovp_deglitch #(.DG(DG_CYC)) i_deglitch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (ovp_i & ~clr),
    .clr_i  (clr),
    .flt_o  (fault_o)
  );

  assign conv_off_o = act;
  assign fet_on_o   = act;
endmodule

// File: rtl/bovp_monitor_chk.sv
module bovp_monitor_chk #(
  parameter int unsigned DG = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ovp_i,
  input logic below_rch_i,
  input logic hiz_i,
  input logic dis_i,
  input logic conv_off_o,
  input logic fet_on_o,
  input logic fault_o
);
  localparam int unsigned RW = $clog2(DG + 2);

  logic          clr;
  logic [RW-1:0] run_q;

  assign clr = below_rch_i | hiz_i | dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (ovp_i && !clr)     run_q <= (run_q == RW'(DG)) ? run_q : run_q + 1'b1;
    else                        run_q <= '0;
  end

  a_r2_act_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovp_i && !clr) |-> (conv_off_o && fet_on_o));

  a_r3_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_off_o |=> (conv_off_o || clr));

  a_r4_release_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> (!conv_off_o && !fet_on_o));

  a_r5_fault_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !fault_o);

  a_r7_deglitch_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> (run_q >= RW'(DG)));

  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr) |=> fault_o);
endmodule

bind bovp_monitor bovp_monitor_chk #(.DG(DG_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ovp_i       (ovp_i),
  .below_rch_i (below_rch_i),
  .hiz_i       (hiz_i),
  .dis_i       (dis_i),
  .conv_off_o  (conv_off_o),
  .fet_on_o    (fet_on_o),
  .fault_o     (fault_o)
);

// File: tb/test_bovp_monitor.sv
module test_bovp_monitor;
  localparam int unsigned FHZ = 1_000_000;
  localparam int unsigned WUS = 16;
  localparam int unsigned DG  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovp = 1'b0, brch = 1'b0, hiz = 1'b0, dis = 1'b0;
  logic conv_off, fet_on, fault;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  bovp_monitor #(.CLK_FREQ_HZ(FHZ), .DEGLITCH_US(WUS)) i_bovp_monitor (
    .clk_i(clk), .rst_ni(rst_n), .ovp_i(ovp), .below_rch_i(brch),
    .hiz_i(hiz), .dis_i(dis), .conv_off_o(conv_off), .fet_on_o(fet_on), .fault_o(fault)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_clear();
    ovp = 0; brch = 1; step(1); brch = 0; step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk(conv_off, 0, "R1", "conv_off in reset");
    chk(fault,    0, "R1", "fault in reset");
    rst_n = 1; step(2);
    chk(conv_off, 0, "R1", "conv_off after reset");
    chk(fet_on,   0, "R1", "fet_on after reset");
    chk(fault,    0, "R1", "fault after reset");
  endtask

  task automatic t_glitch();
    ovp = 1; #1;
    chk(conv_off, 1, "R2", "conv_off same cycle");
    chk(fet_on,   1, "R2", "fet_on same cycle");
    step(1); ovp = 0; step(3);
    chk(conv_off, 1, "R3", "conv_off held");
    chk(fet_on,   1, "R3", "fet_on held");
    chk(fault,    0, "R7", "no fault after glitch");
    brch = 1; #1;
    chk(conv_off, 0, "R4", "release same cycle");
    chk(fet_on,   0, "R4", "fet release same cycle");
    step(1); brch = 0; step(1);
    chk(conv_off, 0, "R4", "stays released");
  endtask

  task automatic t_deglitch_edge();
    ovp = 1; step(DG - 1);
    chk(fault, 0, "R7", "fault at DG-1 edges");
    step(1);
    chk(fault, 1, "R7", "fault at DG edges");
    ovp = 0; step(4);
    chk(fault, 1, "R9", "fault sticky after flag drop");
    chk(conv_off, 1, "R9", "action held with fault");
    brch = 1; step(1); brch = 0; #1;
    chk(fault, 0, "R9", "fault cleared by below_rch");
    step(1);
  endtask

  task automatic t_restart();
    ovp = 1; step(DG - 1);
    ovp = 0; step(1);
    ovp = 1; step(DG - 1);
    chk(fault, 0, "R8", "restart after dropout");
    step(1);
    chk(fault, 1, "R8", "fault after full fresh run");
    ovp = 0; idle_clear();
  endtask

  task automatic t_hiz();
    ovp = 1; step(DG + 1); ovp = 0; step(1);
    chk(fault, 1, "R5", "fault set before hiz");
    hiz = 1; #1;
    chk(conv_off, 0, "R5", "hiz releases conv_off");
    step(1);
    chk(fault, 0, "R5", "hiz clears fault");
    hiz = 0; step(1);
    chk(fet_on, 0, "R5", "fet stays off after hiz");
  endtask

  task automatic t_dis();
    ovp = 1; step(DG + 1); ovp = 0; step(1);
    chk(fault, 1, "R6", "fault set before dis");
    dis = 1; #1;
    chk(fet_on, 0, "R6", "dis releases fet_on");
    step(1);
    chk(fault, 0, "R6", "dis clears fault");
    dis = 0; step(1);
    chk(conv_off, 0, "R6", "conv stays off-released after dis");
  endtask

  task automatic t_priority();
    hiz = 1; ovp = 1; #1;
    chk(conv_off, 0, "R10", "clear beats flag");
    step(DG + 4);
    chk(fault, 0, "R10", "no count while clear");
    hiz = 0; #1;
    chk(conv_off, 1, "R10", "flag acts once clear lifts");
    step(DG - 1);
    chk(fault, 0, "R10", "count started fresh");
    ovp = 0; idle_clear();
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_deglitch_edge();
    t_restart();
    t_hiz();
    t_dis();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule